// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive. After reset it waits out the power-up pause. It then runs a burst of initialisation refresh cycles. From then on it issues one refresh every programmable interval, so the full set of rows is covered within the retention period (4096 rows per 64 ms gives roughly one refresh every 15.6 µs). A build-time parameter selects one of two refresh styles. In the CAS-before-RAS style the memory's internal row counter picks the row, and WE stays high so the memory cannot enter its test mode. In the RAS-only style the block presents a row address from its own wrapping counter while CAS stays high.

The block drives strobe and address requests into a shared strobe multiplexer, and `ref_own_o` selects the scheduler's side of that multiplexer. The host access path asks for the strobes with `host_req_i`. It may start an access only in a cycle where `host_gnt_o` is high, and it holds `host_req_i` high until that access has finished. While the host holds the strobes, due refreshes are postponed and counted. Once the count of owed refreshes reaches its limit, the grant is withdrawn. When the host lets go, all owed refreshes run back to back.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n_o`, `cas_n_o` and `we_n_o` are high, and `host_gnt_o` and `ref_own_o` are low.
- R2: Neither strobe goes low during the first PWRUP_CYC cycles after reset is released.
- R3: After the pause, exactly INIT_CNT (default 8) refresh cycles run back to back in the configured style. `host_gnt_o` stays low until they are complete.
- R4: In CAS-before-RAS style (MODE_CBR=1), `cas_n_o` goes low exactly T_SU cycles before `ras_n_o` falls and stays low for as long as `ras_n_o` is low. `we_n_o` is high throughout.
- R5: In RAS-only style (MODE_CBR=0), `cas_n_o` stays high. `addr_o` carries the row counter, which starts at 0 after reset and advances by one per refresh cycle, modulo 2^ROW_W (4096 by default), including the initialisation cycles.
- R6: `ras_n_o` stays low for exactly T_RAS cycles. After it rises, it stays high for at least T_RP cycles before it falls again.
- R7: After initialisation, one refresh becomes owed every REF_INTERVAL cycles. With the host idle, each owed refresh is carried out before the next one falls due.
- R8: While `host_req_i` is high, no refresh starts. `host_gnt_o` stays high while fewer than MAX_OWED refreshes are owed and drops once MAX_OWED are owed. It returns high once the owed refreshes have been paid off.
- R9: The owed count saturates at MAX_OWED. When the host releases, exactly the saturated number of refreshes run back to back, one every T_SU+T_RAS+T_RP+1 cycles.
- R10: `ref_own_o` is high whenever either strobe is low, and `host_gnt_o` is never high while `ref_own_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access path wants or holds the strobes |
| host_gnt_o | output | 1 | Host may start an access this cycle |
| ref_own_o | output | 1 | Strobe multiplexer select: scheduler drives the memory |
| ras_n_o | output | 1 | Requested row strobe, active low |
| cas_n_o | output | 1 | Requested column strobe, active low |
| we_n_o | output | 1 | Requested write enable, active low (held high) |
| addr_o | output | ROW_W | Requested row address (RAS-only style) |

## Verification
On every cycle the assertions check the following: strobe silence during the power-up pause, the CAS lead and hold around each RAS fall in CAS-before-RAS style, CAS staying high and the row address stepping by one in RAS-only style, the RAS low and precharge widths, and the exclusion between ownership and grant. Other behaviours appear only over the bench's timed scenarios: the count of initialisation cycles, the refresh rate with an idle host, grant withdrawal at the postponement limit, saturation of the owed count, and back-to-back spacing after release. The row counter wrap is observed as well.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SETUP, SEQ_ACTIVE, SEQ_PRECH} seq_state_e;
  typedef enum logic [1:0] {CTL_PWRUP, CTL_INIT, CTL_RUN} ctl_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= RELOAD;
    else if (!en_i)       cnt_q <= RELOAD;
    else if (tick_o)      cnt_q <= RELOAD;
    else                  cnt_q <= cnt_q - TW'(1);
  end
endmodule

// File: rtl/ref_owed_tracker.sv
module ref_owed_tracker #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  output logic pending_o,
  output logic at_limit_o
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] LIMIT = OW'(MAX_OWED);

  logic [OW-1:0] owed_q;

  assign pending_o  = (owed_q != '0);
  assign at_limit_o = (owed_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
    end else begin
      unique case ({tick_i, done_i})
        2'b10: if (owed_q != LIMIT) owed_q <= owed_q + OW'(1);
        2'b01: if (owed_q != '0)    owed_q <= owed_q - OW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
  import dram_ref_pkg::*;
#(
  parameter bit          MODE_CBR = 1'b1,
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned T_SU     = 1,
  parameter int unsigned T_RAS    = 6,
  parameter int unsigned T_RP     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int unsigned LEN_MAX = max3(T_SU, T_RAS, T_RP);
  localparam int unsigned CW      = $clog2(LEN_MAX + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_IDLE:
        if (start_i) begin
          state_d = SEQ_SETUP;
          cnt_d   = CW'(T_SU - 1);
        end
      SEQ_SETUP:
        if (last) begin
          state_d = SEQ_ACTIVE;
          cnt_d   = CW'(T_RAS - 1);
        end else cnt_d = cnt_q - CW'(1);
      SEQ_ACTIVE:
        if (last) begin
          state_d = SEQ_PRECH;
          cnt_d   = CW'(T_RP - 1);
        end else cnt_d = cnt_q - CW'(1);
      SEQ_PRECH:
        if (last) state_d = SEQ_IDLE;
        else      cnt_d   = cnt_q - CW'(1);
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = (state_q == SEQ_PRECH) && last;
  assign ras_n_o = (state_q != SEQ_ACTIVE);
  // WE low at the RAS fall would turn a CBR cycle into test-mode entry
  assign we_n_o  = 1'b1;

  if (MODE_CBR) begin : g_cbr
    assign cas_n_o = !((state_q == SEQ_SETUP) || (state_q == SEQ_ACTIVE));
    assign addr_o  = '0;
  end else begin : g_ras_only
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     row_q <= '0;
      else if (done_o) row_q <= row_q + ROW_W'(1);
    end
    assign cas_n_o = 1'b1;
    assign addr_o  = row_q;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter bit          MODE_CBR     = 1'b1,
  parameter int unsigned ROW_W        = 12,
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned PWRUP_CYC    = 20000,
  parameter int unsigned INIT_CNT     = 8,
  parameter int unsigned MAX_OWED     = 8,
  parameter int unsigned T_SU         = 1,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RP         = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_req_i,
  output logic             host_gnt_o,
  output logic             ref_own_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int unsigned PW = $clog2(PWRUP_CYC + 1);
  localparam int unsigned IW = $clog2(INIT_CNT + 1);

  ctl_state_e    ctl_q;
  logic [PW-1:0] pw_cnt_q;
  logic [IW-1:0] init_left_q;
  logic          seq_busy, seq_done, start, tick, pending, at_limit, in_run;

  assign in_run = (ctl_q == CTL_RUN);
  assign start  = !seq_busy &&
                  (((ctl_q == CTL_INIT) && (init_left_q != '0)) ||
                   (in_run && pending && !host_req_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= CTL_PWRUP;
      pw_cnt_q    <= PW'(PWRUP_CYC - 1);
      init_left_q <= IW'(INIT_CNT);
    end else begin
      unique case (ctl_q)
        CTL_PWRUP:
          if (pw_cnt_q == '0) ctl_q <= CTL_INIT;
          else                pw_cnt_q <= pw_cnt_q - PW'(1);
        CTL_INIT: begin
          if (seq_done) init_left_q <= init_left_q - IW'(1);
          if ((init_left_q == '0) && !seq_busy) ctl_q <= CTL_RUN;
        end
        default: ;
      endcase
    end
  end

  ref_interval_timer #(
    .INTERVAL(REF_INTERVAL)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_run),
    .tick_o (tick)
  );

  ref_owed_tracker #(
    .MAX_OWED(MAX_OWED)
  ) i_owed (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .done_i     (seq_done && in_run),
    .pending_o  (pending),
    .at_limit_o (at_limit)
  );

  ref_strobe_seq #(
    .MODE_CBR (MODE_CBR),
    .ROW_W    (ROW_W),
    .T_SU     (T_SU),
    .T_RAS    (T_RAS),
    .T_RP     (T_RP)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (seq_busy),
    .done_o  (seq_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .addr_o  (addr_o)
  );

  // host may only start while nothing is owed beyond the limit and strobes are free
  assign host_gnt_o = in_run && !seq_busy && !start && !at_limit;
  assign ref_own_o  = seq_busy;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter bit          MODE_CBR  = 1'b1,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned PWRUP_CYC = 20000,
  parameter int unsigned T_SU      = 1,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RP      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             host_gnt_o,
  input logic             ref_own_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic [ROW_W-1:0] addr_o
);
  localparam int unsigned PW   = $clog2(PWRUP_CYC + 1);
  localparam int unsigned CAP  = T_RAS + T_RP + T_SU + 2;
  localparam int unsigned CW   = $clog2(CAP + 1);

  logic [PW-1:0]    since_q;
  logic [CW-1:0]    low_q, high_q;
  logic             ras_prev_q, seen_fall_q;
  logic [ROW_W-1:0] last_row_q;
  logic             fall_w, rise_w;

  assign fall_w = ras_prev_q && !ras_n_o;
  assign rise_w = !ras_prev_q && ras_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q     <= '0;
      low_q       <= '0;
      high_q      <= '0;
      ras_prev_q  <= 1'b1;
      seen_fall_q <= 1'b0;
      last_row_q  <= '0;
    end else begin
      if (since_q != PW'(PWRUP_CYC)) since_q <= since_q + PW'(1);
      low_q  <= ras_n_o ? '0 : ((low_q == CW'(CAP)) ? low_q : low_q + CW'(1));
      high_q <= !ras_n_o ? '0 : ((high_q == CW'(CAP)) ? high_q : high_q + CW'(1));
      ras_prev_q <= ras_n_o;
      if (fall_w) begin
        seen_fall_q <= 1'b1;
        last_row_q  <= addr_o;
      end
    end
  end

  p_quiet_pwrup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q < PW'(PWRUP_CYC)) |-> (ras_n_o && cas_n_o));

  p_cbr_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_CBR && fall_w) |-> (!cas_n_o && $past(!cas_n_o) && we_n_o));

  p_cbr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE_CBR && !ras_n_o) |-> (!cas_n_o && we_n_o));

  p_ras_only_cas_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!MODE_CBR && !ras_n_o) |-> cas_n_o);

  p_row_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!MODE_CBR && fall_w && seen_fall_q) |-> (addr_o == ROW_W'(last_row_q + ROW_W'(1))));

  p_ras_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_w |-> (low_q == CW'(T_RAS)));

  p_precharge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_w |-> (high_q >= CW'(T_RP)));

  p_strobe_owned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> ref_own_o);

  p_gnt_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_own_o |-> !host_gnt_o);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .MODE_CBR  (MODE_CBR),
  .ROW_W     (ROW_W),
  .PWRUP_CYC (PWRUP_CYC),
  .T_SU      (T_SU),
  .T_RAS     (T_RAS),
  .T_RP      (T_RP)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_gnt_o (host_gnt_o),
  .ref_own_o  (ref_own_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .addr_o     (addr_o)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP = 60;
  localparam int INTV  = 40;
  localparam int MAXO  = 3;
  localparam int INITN = 8;
  localparam int TSU   = 2;
  localparam int TRAS  = 4;
  localparam int TRP   = 3;
  localparam int RO_W  = 4;
  localparam int SPAN  = TSU + TRAS + TRP + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0;

  logic gnt_a, own_a, ras_a, cas_a, we_a;
  logic [11:0] addr_a;
  logic gnt_b, own_b, ras_b, cas_b, we_b;
  logic [RO_W-1:0] addr_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_sched #(
    .MODE_CBR(1'b1), .ROW_W(12), .REF_INTERVAL(INTV), .PWRUP_CYC(PWRUP),
    .INIT_CNT(INITN), .MAX_OWED(MAXO), .T_SU(TSU), .T_RAS(TRAS), .T_RP(TRP)
  ) i_dram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_gnt_o(gnt_a),
    .ref_own_o(own_a), .ras_n_o(ras_a), .cas_n_o(cas_a), .we_n_o(we_a), .addr_o(addr_a)
  );

  dram_refresh_sched #(
    .MODE_CBR(1'b0), .ROW_W(RO_W), .REF_INTERVAL(INTV), .PWRUP_CYC(PWRUP),
    .INIT_CNT(INITN), .MAX_OWED(MAXO), .T_SU(TSU), .T_RAS(TRAS), .T_RP(TRP)
  ) i_dram_refresh_sched_ro (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_gnt_o(gnt_b),
    .ref_own_o(own_b), .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b), .addr_o(addr_b)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard of expected RAS-only row addresses
  int exp_rows[$];
  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) exp_rows.push_back(i % (1 << RO_W));
  endtask

  // monitor: CAS-before-RAS instance
  logic pras_a = 1'b1;
  int cas_run_a = 0, low_a = 0, falls_a = 0;
  int fall_t_a[$];
  always @(negedge clk) if (rst_n) begin
    if (!cas_a) cas_run_a++; else cas_run_a = 0;
    if (pras_a && !ras_a) begin
      falls_a++;
      fall_t_a.push_back(cyc);
      check(cas_run_a == TSU + 1, "R4", "CAS low cycles at RAS fall", cas_run_a, TSU + 1);
      check(we_a == 1'b1, "R4", "WE at RAS fall", we_a, 1);
      check(own_a && !gnt_a, "R10", "own/gnt at RAS fall", {own_a, gnt_a}, 2);
    end
    if (!ras_a) check(cas_a == 1'b0, "R4", "CAS held during RAS low", cas_a, 0);
    if (!pras_a && ras_a) check(low_a == TRAS, "R6", "RAS low width", low_a, TRAS);
    low_a = ras_a ? 0 : low_a + 1;
    pras_a = ras_a;
  end

  // monitor: RAS-only instance, pops the scoreboard
  logic pras_b = 1'b1;
  int low_b = 0, falls_b = 0;
  int fall_t_b[$];
  always @(negedge clk) if (rst_n) begin
    if (pras_b && !ras_b) begin
      int exp_row;
      falls_b++;
      fall_t_b.push_back(cyc);
      exp_row = (exp_rows.size() > 0) ? exp_rows.pop_front() : -1;
      check(int'(addr_b) == exp_row, "R5", "row address", addr_b, exp_row);
      check(cas_b == 1'b1, "R5", "CAS at RAS-only fall", cas_b, 1);
      check(own_b && !gnt_b, "R10", "own/gnt at RAS fall", {own_b, gnt_b}, 2);
    end
    if (!pras_b && ras_b) check(low_b == TRAS, "R6", "RAS low width", low_b, TRAS);
    low_b = ras_b ? 0 : low_b + 1;
    pras_b = ras_b;
  end

  int g = 0;
  task automatic wait_n(input int n);
    while (cyc - g < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int rel, f1a, f1b, f2a, f2b;
    push_rows(40);
    repeat (3) @(negedge clk);
    check(ras_a && cas_a && we_a && !gnt_a && !own_a, "R1", "reset outputs CBR",
          {ras_a, cas_a, we_a, gnt_a, own_a}, 5'b11100);
    check(ras_b && cas_b && we_b && !gnt_b && !own_b, "R1", "reset outputs RAS-only",
          {ras_b, cas_b, we_b, gnt_b, own_b}, 5'b11100);
    rst_n = 1'b1;
    rel = cyc;

    while (!gnt_a) @(negedge clk);
    g = cyc;
    check(falls_a == INITN, "R3", "init cycles CBR", falls_a, INITN);
    check(falls_b == INITN, "R3", "init cycles RAS-only", falls_b, INITN);
    check(gnt_b == 1'b1, "R3", "grant after init", gnt_b, 1);
    check(fall_t_a[0] - rel >= PWRUP, "R2", "first RAS fall after pause", fall_t_a[0] - rel, PWRUP);
    check(fall_t_a[INITN-1] - fall_t_a[0] == (INITN - 1) * SPAN, "R3", "init back to back",
          fall_t_a[INITN-1] - fall_t_a[0], (INITN - 1) * SPAN);

    // idle host: one refresh per interval
    wait_n(220);
    check(falls_a - INITN == 5, "R7", "refreshes in 5 intervals CBR", falls_a - INITN, 5);
    check(falls_b - INITN == 5, "R7", "refreshes in 5 intervals RAS-only", falls_b - INITN, 5);

    // host holds the strobes
    host_req = 1'b1;
    f1a = falls_a;
    f1b = falls_b;
    wait_n(300);
    check(gnt_a == 1'b1, "R8", "grant below limit", gnt_a, 1);
    check(gnt_b == 1'b1, "R8", "grant below limit", gnt_b, 1);
    wait_n(330);
    check(gnt_a == 1'b0, "R8", "stall at limit", gnt_a, 0);
    check(gnt_b == 1'b0, "R8", "stall at limit", gnt_b, 0);
    wait_n(441);
    check(falls_a == f1a, "R8", "no refresh while host holds", falls_a - f1a, 0);
    check(falls_b == f1b, "R8", "no refresh while host holds", falls_b - f1b, 0);
    host_req = 1'b0;
    f2a = falls_a;
    f2b = falls_b;

    wait_n(475);
    check(gnt_a == 1'b1, "R8", "grant restored", gnt_a, 1);
    wait_n(479);
    check(falls_a - f2a == MAXO, "R9", "saturated drain CBR", falls_a - f2a, MAXO);
    check(falls_b - f2b == MAXO, "R9", "saturated drain RAS-only", falls_b - f2b, MAXO);
    if (falls_a - f2a >= 3) begin
      check(fall_t_a[f2a+1] - fall_t_a[f2a] == SPAN, "R9", "drain spacing",
            fall_t_a[f2a+1] - fall_t_a[f2a], SPAN);
      check(fall_t_a[f2a+2] - fall_t_a[f2a+1] == SPAN, "R9", "drain spacing",
            fall_t_a[f2a+2] - fall_t_a[f2a+1], SPAN);
    end

    // run on so the RAS-only row counter wraps
    wait_n(800);
    check(falls_b > (1 << RO_W), "R5", "row counter wrap reached", falls_b, (1 << RO_W) + 1);
    check(falls_a == falls_b, "R7", "both styles same rate", falls_a, falls_b);
    finish_run();
  end
endmodule